// File: doc/BRIEF.md
# Per-Pixel Direct/Indexed Colour Selector

This block turns a stream of pixels into 24-bit RGB, one pixel per cycle. Each pixel arrives as three words in parallel: an 8-bit palette index, a 32-bit packed true-colour word and a 32-bit control word. The control word picks, per pixel, whether the true-colour word is unpacked and shown directly or the index is looked up in an external palette memory. The block drives the palette read port itself and merges the two paths so that pixels leave in the order they entered.

Input and output use a valid/ready handshake. One global stall covers all three input streams: when the output is held, nothing is taken in. A column counter marks the last visible pixel of each line. Lines sit on a fixed pitch of 1024 pixels in memory. The visible width can be anything from 1 to that pitch.

Top module: `pix_color_sel`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, `in_ready` is 1 and `pal_en` is 0.
- R2: A pixel is direct when `in_ctrl[31:24]` equals 8'h03. Its output is R = `in_direct[7:0]`, G = `in_direct[15:8]` and B = `in_direct[23:16]`. `in_direct[31:24]` has no effect on it.
- R3: Any other value of `in_ctrl[31:24]` makes the pixel indexed, whatever `in_ctrl[23:0]` holds.
- R4: For an indexed pixel, `pal_addr` carries `in_index` and `pal_en` is high for one advancing cycle. The palette returns `{R,G,B}` on `pal_rgb` one clock after that cycle, and that value is output unchanged.
- R5: With `out_ready` high, a pixel accepted at clock edge k is presented at the output after edge k+2, which is three cycles later. Pixels leave in acceptance order, with direct and indexed pixels mixed freely.
- R6: While `out_valid` is 1 and `out_ready` is 0, the output pixel and `out_last` hold their values on the next cycle.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. No pixel is lost or duplicated under any backpressure pattern.
- R8: Accepted pixels are numbered by column from 0 after reset. `out_last` is 1 exactly on the pixel at column `vis_width`−1, and the next pixel is column 0.
- R9: A `vis_width` of 0, or a value above the pitch of 1024, counts as a full line of 1024 pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vis_width | input | 11 | Visible pixels per line (0 = full pitch) |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block takes the input pixel this cycle |
| in_index | input | 8 | Palette index of the pixel |
| in_direct | input | 32 | Packed true-colour word |
| in_ctrl | input | 32 | Per-pixel control word; top byte selects the mode |
| pal_en | output | 1 | Palette read strobe |
| pal_addr | output | 8 | Palette read address |
| pal_rgb | input | 24 | Palette data, {R,G,B}, one cycle after `pal_en` |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Sink takes the output pixel |
| out_rgb | output | 24 | Output colour {R,G,B} |
| out_last | output | 1 | Output pixel is the last visible pixel of its line |

## Verification
Some properties are checked on every cycle. These are the stall rules: a held output stays stable and blocks the input. Timing through the pipe is also checked every cycle: an advancing valid stage fills the next one, and a bubble empties the output. The column counter must return to zero after an end-of-line pixel. Other behaviour depends on data values and needs the bench's scenarios. This covers the 8'h03 tag decode against neighbouring values, the byte order of the unpacked word, the palette round trip and the position of `out_last` for narrow, single-pixel and full-pitch lines.

// File: rtl/pcs_pkg.sv
// Shared types and helpers for the colour selector.
// Assumes a packed true-colour word laid out as {unused, B, G, R}.
package pcs_pkg;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    localparam logic [7:0] DIRECT_TAG = 8'h03;

    // Unpack a true-colour word; the top byte is discarded.
    function automatic rgb_t unpack_bgr(input logic [31:0] w);
        rgb_t c;
        c.r = w[7:0];
        c.g = w[15:8];
        c.b = w[23:16];
        return c;
    endfunction

endpackage

// File: rtl/pcs_decode.sv
// Stage 1: decodes the per-pixel mode, unpacks true colour and
// tracks the column for end-of-line marking.
// Assumes vis_width is steady while a line is in flight.
module pcs_decode
    import pcs_pkg::*;
#(
    parameter int PITCH = 1024,
    parameter int CW    = $clog2(PITCH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] vis_width,
    input  logic          in_valid,
    input  logic [7:0]    in_index,
    input  logic [31:0]   in_direct,
    input  logic [31:0]   in_ctrl,
    output logic          s1_valid,
    output logic          s1_direct,
    output rgb_t          s1_rgb,
    output logic [7:0]    s1_index,
    output logic          s1_last
);
    localparam logic [CW-1:0] PITCH_W = CW'(PITCH);

    logic [CW-1:0] lim;
    logic [CW-1:0] col;
    logic          at_end;
    logic          take;

    // Effective line width: zero or oversize means the full pitch.
    always_comb begin
        if (vis_width == '0 || vis_width > PITCH_W) lim = PITCH_W;
        else                                        lim = vis_width;
    end

    assign at_end = (col >= lim - CW'(1));
    assign take   = en && in_valid;

    // Column counter, advanced per accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)    col <= '0;
        else if (take) col <= at_end ? '0 : col + CW'(1);
    end

    // First pipeline register: mode, colour and line position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_direct <= 1'b0;
            s1_rgb    <= '0;
            s1_index  <= '0;
            s1_last   <= 1'b0;
        end else if (en) begin
            s1_valid  <= in_valid;
            s1_direct <= (in_ctrl[31:24] == DIRECT_TAG);
            s1_rgb    <= unpack_bgr(in_direct);
            s1_index  <= in_index;
            s1_last   <= in_valid && at_end;
        end
    end

    AST_LAST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && at_end) |=> (col == '0)); // R8

endmodule

// File: rtl/pcs_align.sv
// Stage 2: holds pixel attributes for the cycle in which the
// palette memory answers, keeping both colour paths aligned.
// Assumes a palette read latency of exactly one clock.
module pcs_align
    import pcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic s1_valid,
    input  logic s1_direct,
    input  rgb_t s1_rgb,
    input  logic s1_last,
    output logic s2_valid,
    output logic s2_direct,
    output rgb_t s2_rgb,
    output logic s2_last
);
    // Delay register matching the palette access cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid  <= 1'b0;
            s2_direct <= 1'b0;
            s2_rgb    <= '0;
            s2_last   <= 1'b0;
        end else if (en) begin
            s2_valid  <= s1_valid;
            s2_direct <= s1_direct;
            s2_rgb    <= s1_rgb;
            s2_last   <= s1_last;
        end
    end

    AST_STAGE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s1_valid) |=> s2_valid); // R5

endmodule

// File: rtl/pcs_merge.sv
// Stage 3: picks true colour or palette data and registers
// the output pixel.
// Assumes pal_rgb is stable while the pipe is stalled.
module pcs_merge
    import pcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        s2_valid,
    input  logic        s2_direct,
    input  rgb_t        s2_rgb,
    input  logic        s2_last,
    input  logic [23:0] pal_rgb,
    output logic        out_valid,
    output logic [23:0] out_rgb,
    output logic        out_last
);
    rgb_t pick;

    // Colour source choice for the pixel in stage 2.
    always_comb pick = s2_direct ? s2_rgb : rgb_t'(pal_rgb);

    // Output register; it only moves when the pipe advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
            out_last  <= 1'b0;
        end else if (en) begin
            out_valid <= s2_valid;
            out_rgb   <= pick;
            out_last  <= s2_valid && s2_last;
        end
    end

    AST_BUBBLE_PROP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !s2_valid) |=> !out_valid); // R5

endmodule

// File: rtl/pix_color_sel.sv
// Top: per-pixel direct/indexed colour selection, three stages deep.
// All stages share one advance enable, so backpressure stalls
// every input stream and the palette port together.
// Assumes a synchronous palette memory that updates pal_rgb only
// on a clock where pal_en is high.
module pix_color_sel
    import pcs_pkg::*;
#(
    parameter int PITCH = 1024,
    parameter int CW    = $clog2(PITCH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] vis_width,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_index,
    input  logic [31:0]   in_direct,
    input  logic [31:0]   in_ctrl,
    output logic          pal_en,
    output logic [7:0]    pal_addr,
    input  logic [23:0]   pal_rgb,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [23:0]   out_rgb,
    output logic          out_last
);
    logic en;
    logic s1_valid, s1_direct, s1_last;
    logic s2_valid, s2_direct, s2_last;
    rgb_t s1_rgb, s2_rgb;
    logic [7:0] s1_index;

    // Global advance: the output slot is free or being drained.
    assign en       = !out_valid || out_ready;
    assign in_ready = en;
    assign pal_addr = s1_index;
    assign pal_en   = en && s1_valid && !s1_direct;

    pcs_decode #(.PITCH(PITCH), .CW(CW)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .vis_width (vis_width),
        .in_valid  (in_valid),
        .in_index  (in_index),
        .in_direct (in_direct),
        .in_ctrl   (in_ctrl),
        .s1_valid  (s1_valid),
        .s1_direct (s1_direct),
        .s1_rgb    (s1_rgb),
        .s1_index  (s1_index),
        .s1_last   (s1_last)
    );

    pcs_align u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .s1_valid  (s1_valid),
        .s1_direct (s1_direct),
        .s1_rgb    (s1_rgb),
        .s1_last   (s1_last),
        .s2_valid  (s2_valid),
        .s2_direct (s2_direct),
        .s2_rgb    (s2_rgb),
        .s2_last   (s2_last)
    );

    pcs_merge u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .s2_valid  (s2_valid),
        .s2_direct (s2_direct),
        .s2_rgb    (s2_rgb),
        .s2_last   (s2_last),
        .pal_rgb   (pal_rgb),
        .out_valid (out_valid),
        .out_rgb   (out_rgb),
        .out_last  (out_last)
    );

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_rgb) && $stable(out_last))); // R6

    AST_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R7

endmodule

// File: tb/pix_color_sel_tb.sv
module pix_color_sel_tb;
    localparam int PITCH = 1024;
    localparam int CW    = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] vis_width = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_index = '0;
    logic [31:0]   in_direct = '0;
    logic [31:0]   in_ctrl = '0;
    logic          pal_en;
    logic [7:0]    pal_addr;
    logic [23:0]   pal_rgb = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [23:0]   out_rgb;
    logic          out_last;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int acc_cyc = 0;
    int out_cyc = 0;
    int bcol    = 0;
    bit bp_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [24:0] exp_q[$];
    bit   prev_stall = 1'b0;
    logic [23:0] prev_rgb = '0;
    logic prev_last = 1'b0;

    always #10 clk = ~clk;

    pix_color_sel #(.PITCH(PITCH), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .vis_width(vis_width),
        .in_valid(in_valid), .in_ready(in_ready), .in_index(in_index),
        .in_direct(in_direct), .in_ctrl(in_ctrl), .pal_en(pal_en),
        .pal_addr(pal_addr), .pal_rgb(pal_rgb), .out_valid(out_valid),
        .out_ready(out_ready), .out_rgb(out_rgb), .out_last(out_last)
    );

    function automatic logic [23:0] pal_f(input logic [7:0] a);
        return {a ^ 8'hA5, a + 8'd31, ~a};
    endfunction

    // Palette memory model: synchronous read, holds when not enabled.
    always @(posedge clk) if (pal_en) pal_rgb <= pal_f(pal_addr);

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int eff_w();
        return (vis_width == 0 || vis_width > CW'(PITCH)) ? PITCH : int'(vis_width);
    endfunction

    // Backpressure generator.
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready <= bp_mode ? (lfsr[0] | lfsr[3]) & ~lfsr[7] : 1'b1;
    end

    // Monitor: samples just before each rising edge.
    always @(negedge clk) begin
        #9;
        cyc++;
        if (rst_n) begin
            if (prev_stall) begin
                check(out_valid && out_rgb == prev_rgb && out_last == prev_last,
                      "R6 stall hold", {7'd0, out_last, out_rgb}, {7'd0, prev_last, prev_rgb});
            end
            if (out_valid && !out_ready)
                check(!in_ready, "R7 in_ready low under stall", 32'(in_ready), 32'd0);
            if (in_valid && in_ready) begin
                logic [23:0] e;
                logic        l;
                if (in_ctrl[31:24] == 8'h03) e = {in_direct[7:0], in_direct[15:8], in_direct[23:16]};
                else                         e = pal_f(in_index);
                l = (bcol == eff_w() - 1);
                bcol = l ? 0 : bcol + 1;
                exp_q.push_back({l, e});
                acc_cyc = cyc;
            end
            if (out_valid && out_ready) begin
                out_cyc = cyc;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected output", {7'd0, out_last, out_rgb}, 32'd0);
                end else begin
                    logic [24:0] h;
                    h = exp_q.pop_front();
                    check({out_last, out_rgb} == h, "R2/R3/R4/R5/R8 pixel",
                          {7'd0, out_last, out_rgb}, {7'd0, h});
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_rgb   = out_rgb;
            prev_last  = out_last;
        end else begin
            prev_stall = 1'b0;
            bcol = 0;
        end
    end

    // Offer one pixel; called at a falling edge, returns at one.
    task automatic push(input logic [7:0] idx, input logic [31:0] dir, input logic [31:0] ctl);
        bit got;
        in_valid = 1'b1; in_index = idx; in_direct = dir; in_ctrl = ctl;
        got = 1'b0;
        while (!got) begin
            #9;
            got = in_ready;
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int n;
        n = 0;
        while (exp_q.size() != 0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R7 all pixels delivered", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic do_reset(input logic [CW-1:0] w);
        @(negedge clk);
        rst_n = 1'b0; vis_width = w; in_valid = 1'b0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(11'd0);
        #9;
        check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);
        check(pal_en == 1'b0, "R1 pal_en after reset", 32'(pal_en), 32'd0);
        @(negedge clk);
    endtask

    task automatic t_direct();
        // R2: tag 8'h03, top byte of true-colour word varies
        push(8'h10, 32'hFF112233, 32'h03FFFFFF);
        push(8'h20, 32'h00ABCDEF, 32'h03000000);
        push(8'h30, 32'h5A000000, 32'h03123456);
        drain();
    endtask

    task automatic t_indexed();
        // R3/R4: top-byte neighbours of the tag and tag-like low bits
        push(8'h00, 32'h00112233, 32'h02000000);
        push(8'hFF, 32'h00112233, 32'h04000000);
        push(8'h7E, 32'h00112233, 32'h83000000);
        push(8'h3C, 32'h00112233, 32'h00030303);
        push(8'h81, 32'h00112233, 32'h13000000);
        drain();
    endtask

    task automatic t_latency();
        // R5: three cycles from acceptance to presentation
        push(8'h44, 32'h0, 32'h01000000);
        drain();
        check(out_cyc - acc_cyc == 3, "R5 latency", 32'(out_cyc - acc_cyc), 32'd3);
        push(8'h00, 32'h00C0FFEE, 32'h03000000);
        drain();
        check(out_cyc - acc_cyc == 3, "R5 latency direct", 32'(out_cyc - acc_cyc), 32'd3);
    endtask

    task automatic t_mixed_stall();
        // R5/R6/R7: mixed modes under random backpressure
        bp_mode = 1'b1;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] ctl;
            ctl = (i % 3 == 0) ? 32'h03000000 : {8'(i), 24'h030303};
            push(8'(i * 7), {8'(i), 8'(i + 1), 8'(i * 3), 8'(i ^ 8'h55)}, ctl);
        end
        drain();
        bp_mode = 1'b0;
        drain();
    endtask

    task automatic t_lines(input logic [CW-1:0] w, input int n);
        // R8/R9: end-of-line marking for a given width
        do_reset(w);
        for (int i = 0; i < n; i++)
            push(8'(i), 32'(i), (i % 2 == 0) ? 32'h03000000 : 32'h00000000);
        drain();
    endtask

    initial begin
        t_reset();
        t_direct();
        t_indexed();
        t_latency();
        t_mixed_stall();
        t_lines(11'd4, 13);     // R8 narrow line
        t_lines(11'd1, 5);      // R8 single-pixel line
        t_lines(11'd0, 1030);   // R9 zero means full pitch
        t_lines(11'd2000, 1026); // R9 oversize means full pitch
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule